// File: doc/BRIEF.md
# Period Averager with Outlier Rejection

This block takes one measured period at a time, such as the count of reference clock ticks between two one-second marks. It keeps a circular buffer of recent periods and reports their mean. Each incoming value is checked against a lower and an upper bound, and both bounds count as inside the window. A value inside the window is stored and moves the write pointer forward. A value outside the window is still written to the current slot, but the pointer stays where it is, so the next sample overwrites it.

A mean is worked out again after every sample that is taken. A small engine adds the needed slots into a wide accumulator, one slot per clock, and then divides in a single step. Before the buffer has wrapped for the first time, the mean covers only the filled slots below the pointer. After it has wrapped, the mean covers every slot. A status code tells which of these cases applies. A one-cycle done pulse marks each new result. Strobes that arrive while the engine is busy are dropped.

Top module: `period_averager`

## Requirements
- R1: Every sample that is taken is written to the slot at the current pointer, even if it is rejected. Once the buffer is full, a rejected value therefore takes part in the next mean.
- R2: A sample below `bound_lo` or above `bound_hi` is rejected. The pointer, `fill_o` and `full_o` stay unchanged. Values equal to either bound are accepted.
- R3: An accepted sample advances the pointer by one. An accepted sample in the last slot (DEPTH-1) wraps the pointer to 0 and sets `full_o`. `full_o` stays set until reset. `fill_o` equals the pointer while not full, and DEPTH once full.
- R4: While `full_o` is 1, each result has `avg_o` = floor(sum of all DEPTH slots / DEPTH) and `status_o` = 2.
- R5: While `full_o` is 0 and the pointer is k > 0, each result has `avg_o` = floor(sum of slots 0..k-1 / k) and `status_o` = 1.
- R6: The sum is kept SUM_W = 64 bits wide. DEPTH periods near 2^32-1 give their exact mean with no wrap-around.
- R7: Reset clears every slot, the pointer and the full flag. After reset, `avg_o`, `status_o`, `fill_o`, `full_o` and `done_o` are all 0.
- R8: If no sample has been accepted since reset, a result still comes with `done_o`, but `avg_o` stays 0 and `status_o` is 0.
- R9: A `sample_valid` strobe that arrives while a mean is being computed is ignored. It changes no slot, pointer or flag.
- R10: `done_o` is high for exactly one cycle. It becomes visible n+2 clock edges after the edge that takes the sample, where n is the number of slots summed (0, k or DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Strobe for a new period |
| sample_period | input | DATA_W | Measured period value |
| bound_lo | input | DATA_W | Lowest accepted period (inclusive) |
| bound_hi | input | DATA_W | Highest accepted period (inclusive) |
| avg_o | output | DATA_W | Most recent mean |
| status_o | output | 2 | 0 no data, 1 partial buffer, 2 full buffer |
| fill_o | output | clog2(DEPTH+1) | Number of valid slots |
| full_o | output | 1 | Sticky buffer-full flag |
| done_o | output | 1 | One-cycle pulse marking a new mean |

## Verification
The pointer, `fill_o` and `full_o` change on the same edge that takes the sample. `avg_o`, `status_o` and `done_o` change n+2 edges later: one setup edge, n accumulate edges and one finish edge. When the driver issues a sample, it works out n from its own model of the buffer and records the cycle in which the result is due. The monitor samples on falling edges. When it sees the done pulse, it checks the mean, the status, the fill count, the flag and the arrival cycle together.

// File: rtl/pavg_pkg.sv
package pavg_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_PART  = 2'd1,
    ST_FULL  = 2'd2
  } pavg_status_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_ACC,
    ENG_FIN
  } pavg_eng_e;

  // Acceptance test: both bounds are inclusive.
  function automatic logic pavg_in_window(input logic [63:0] v,
                                          input logic [63:0] lo,
                                          input logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Truncating mean of a wide sum over a slot count.
  function automatic logic [63:0] pavg_mean(input logic [63:0] sum,
                                            input logic [63:0] n);
    return (n == 64'd0) ? 64'd0 : (sum / n);
  endfunction

endpackage

// File: rtl/pavg_slot_store.sv
module pavg_slot_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              advance,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  idx_o,
  output logic              full_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              full;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      idx  <= '0;
      full <= 1'b0;
    end else if (wr_en) begin
      mem[idx] <= wr_data;
      if (advance) begin
        if (idx == LAST) begin
          idx  <= '0;
          full <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign idx_o   = idx;
  assign full_o  = full;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(idx) < DEPTH); // R3
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    full |=> full); // R3
  AST_WRAP_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && advance && idx == LAST) |=> (idx == '0 && full)); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !advance) |=> ($stable(idx) && $stable(full))); // R2

endmodule

// File: rtl/pavg_mean_engine.sv
module pavg_mean_engine
  import pavg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 64,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  fill_in,
  input  logic              full_in,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] avg_o,
  output logic [1:0]        status_o
);

  pavg_eng_e         state;
  logic [CNT_W-1:0]  n_q;
  logic [CNT_W-1:0]  cnt;
  logic [SUM_W-1:0]  acc;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      n_q      <= '0;
      cnt      <= '0;
      acc      <= '0;
      full_q   <= 1'b0;
      done_o   <= 1'b0;
      avg_o    <= '0;
      status_o <= ST_EMPTY;
    end else begin
      done_o <= 1'b0;
      case (state)
        ENG_IDLE: if (start) state <= ENG_SETUP;
        ENG_SETUP: begin
          n_q    <= fill_in;
          full_q <= full_in;
          acc    <= '0;
          cnt    <= '0;
          state  <= (fill_in == '0) ? ENG_FIN : ENG_ACC;
        end
        ENG_ACC: begin
          acc <= acc + SUM_W'(rd_data);
          cnt <= cnt + CNT_W'(1);
          if (cnt == n_q - CNT_W'(1)) state <= ENG_FIN;
        end
        ENG_FIN: begin
          done_o <= 1'b1;
          state  <= ENG_IDLE;
          if (n_q == '0) begin
            status_o <= ST_EMPTY;
          end else begin
            avg_o    <= DATA_W'(pavg_mean(64'(acc), 64'(n_q)));
            status_o <= full_q ? ST_FULL : ST_PART;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign rd_addr = cnt[IDX_W-1:0];
  assign busy_o  = (state != ENG_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_STATUS_MATCHES_FULL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((status_o == ST_FULL) == full_in)); // R4
  AST_EMPTY_AVG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == ST_EMPTY) |-> (avg_o == '0)); // R8
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_ACC) |-> (cnt < n_q)); // R5

endmodule

// File: rtl/period_averager.sv
module period_averager
  import pavg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int SUM_W  = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_period,
  input  logic [DATA_W-1:0] bound_lo,
  input  logic [DATA_W-1:0] bound_hi,
  output logic [DATA_W-1:0] avg_o,
  output logic [1:0]        status_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              full_o,
  output logic              done_o
);

  logic              busy;
  logic              take;
  logic              accept;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;

  assign take   = sample_valid && !busy;
  assign accept = pavg_in_window(64'(sample_period), 64'(bound_lo), 64'(bound_hi));
  assign fill_o = full_o ? CNT_W'(DEPTH) : CNT_W'(idx);

  pavg_slot_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take),
    .wr_data (sample_period),
    .advance (accept),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .idx_o   (idx),
    .full_o  (full_o)
  );

  pavg_mean_engine #(.DATA_W(DATA_W), .SUM_W(SUM_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (take),
    .fill_in  (fill_o),
    .full_in  (full_o),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy_o   (busy),
    .done_o   (done_o),
    .avg_o    (avg_o),
    .status_o (status_o)
  );

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && sample_valid) |=> ($stable(fill_o) && $stable(full_o))); // R9
  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(fill_o) <= DEPTH); // R3

endmodule

// File: tb/period_averager_tb.sv
module period_averager_tb;

  localparam int DW = 32;
  localparam int DP = 8;
  localparam int CW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sample_valid = 1'b0;
  logic [DW-1:0] sample_period = '0;
  logic [DW-1:0] bound_lo = 32'd1000;
  logic [DW-1:0] bound_hi = 32'd2000;
  logic [DW-1:0] avg_o;
  logic [1:0]    status_o;
  logic [CW-1:0] fill_o;
  logic          full_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  // Scoreboard queues
  logic [DW-1:0] q_avg[$];
  int            q_st[$];
  int            q_fill[$];
  bit            q_full[$];
  longint        q_due[$];
  string         q_tag[$];

  // Bench model of the buffer
  logic [DW-1:0] mslot [DP];
  int            midx = 0;
  bit            mfull = 0;

  period_averager #(.DATA_W(DW), .DEPTH(DP), .SUM_W(64)) u_dut (
    .clk, .rst, .sample_valid, .sample_period, .bound_lo, .bound_hi,
    .avg_o, .status_o, .fill_o, .full_o, .done_o
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DP; i++) mslot[i] = '0;
    midx = 0;
    mfull = 0;
  endtask

  // Driver: predicts the result and pushes it, then drives one strobe.
  task automatic send(input logic [DW-1:0] v, input string tag, input bit extra_strobe);
    logic [63:0] total;
    int n;
    @(negedge clk);
    mslot[midx] = v;
    if (v >= bound_lo && v <= bound_hi) begin
      if (midx == DP - 1) begin midx = 0; mfull = 1; end
      else midx++;
    end
    n = mfull ? DP : midx;
    total = 0;
    for (int i = 0; i < n; i++) total += {32'd0, mslot[i]};
    q_avg.push_back((n == 0) ? 32'd0 : 32'(total / n));
    q_st.push_back(mfull ? 2 : (n == 0 ? 0 : 1));
    q_fill.push_back(n);
    q_full.push_back(mfull);
    q_due.push_back(cyc + n + 3);
    q_tag.push_back(tag);
    sample_valid  = 1'b1;
    sample_period = v;
    @(negedge clk);
    sample_valid = 1'b0;
    if (extra_strobe) begin
      sample_valid  = 1'b1;   // arrives while busy: must be dropped
      sample_period = 32'd1100;
      @(negedge clk);
      sample_valid = 1'b0;
    end
    while (q_avg.size() != 0) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (q_avg.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check(avg_o == q_avg[0], t, "avg", avg_o, q_avg[0]);
        check(int'(status_o) == q_st[0], t, "status", status_o, q_st[0]);
        check(int'(fill_o) == q_fill[0], t, "fill", fill_o, q_fill[0]);
        check(full_o == q_full[0], t, "full", full_o, q_full[0]);
        check(cyc == q_due[0], "R10", "done cycle", cyc, q_due[0]);
        void'(q_avg.pop_front());
        void'(q_st.pop_front());
        void'(q_fill.pop_front());
        void'(q_full.pop_front());
        void'(q_due.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check(avg_o == 0 && status_o == 0, "R7", "avg/status after reset", avg_o, 0);
    check(fill_o == 0 && !full_o && !done_o, "R7", "fill/full/done after reset", fill_o, 0);

    send(32'd500,  "R8", 0);   // rejected before any accept
    send(32'd1500, "R5", 0);
    send(32'd1000, "R2", 0);   // lower bound inclusive
    send(32'd2000, "R2", 0);   // upper bound inclusive
    send(32'd999,  "R2", 0);   // rejected below
    send(32'd2001, "R2", 0);   // rejected above
    send(32'd1700, "R9", 1);   // busy strobe ignored
    send(32'd1200, "R5", 0);
    send(32'd1300, "R5", 0);
    send(32'd1400, "R5", 0);
    send(32'd1600, "R3", 0);   // wraps, sets full
    send(32'd5,    "R1", 0);   // rejected while full still counted
    send(32'd1800, "R4", 1);
    send(32'd1900, "R4", 0);

    bound_lo = 32'd0;
    bound_hi = 32'hFFFF_FFFF;
    for (int i = 0; i < DP; i++) send(32'hFFFF_FFF0, "R6", 0);

    // R7: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(avg_o == 0 && status_o == 0, "R7", "avg/status after second reset", avg_o, 0);
    check(fill_o == 0 && !full_o, "R7", "fill/full after second reset", fill_o, 0);
    bound_lo = 32'd1000;
    bound_hi = 32'd2000;
    send(32'd1234, "R7", 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule